// File: doc/BRIEF.md
# Planar tile pixel shifter

This block turns bitplane tile rows for one background layer into a stream of per-pixel colour indices. Each tile row arrives as one byte per plane, where the byte for plane n holds bit n of all eight pixels of the row. The block keeps two copies of a row. A holding register accepts the next row at any time. A set of per-plane shift registers holds the row that is being displayed. Each enabled pixel clock takes one bit from every plane at the same position and joins them into a colour index. The index leaves the block together with the row's palette and priority attributes and a transparent flag.

When the last pixel of the displayed row leaves, the held row moves into the shift registers, so rows follow each other with no gap. A line-start strobe moves the held row in at once and drops a chosen number of leading pixels, which gives fine horizontal scrolling. A chip with several background layers uses one instance per layer and runs them in lockstep, so that every layer produces its pixel for a screen position in the same cycle. The tilemap address generator, which sits upstream, fetches each row ahead of its display slot and loads it here.

Top module: `tile_pixel_shifter`

## Requirements
- R1: After reset, pix_valid is 0, pix_index is 0, pix_pal is 0, pix_prio is 0 and pix_transp is 1. The held row and the displayed row are all zero.
- R2: Bit p of pix_index comes from the plane-p byte of the displayed row, at the current pixel position. Plane p occupies bits [p*8+7 : p*8] of ld_planes, and plane 0 gives the least significant bit.
- R3: When ld_hflip is 0, a row's pixels leave in the order byte bit 7, 6, down to 0, so the leftmost pixel comes first.
- R4: When ld_hflip is 1 at load time, the row's pixels leave in the order byte bit 0, 1, up to 7.
- R5: pix_valid rises in the cycle after a clock edge with pix_en=1 and line_start=0, and is 0 after any other edge. While pix_valid is 0, the pixel outputs keep their last values.
- R6: After 8 pixels of a row have been output, the next enabled pixel comes from the row that was in the holding register when the 8th pixel left. No pixel slot is skipped or repeated.
- R7: A load with ld_valid=1 may occur in any cycle and does not disturb the row that is being shown. If several loads occur before a transfer, the last one is transferred.
- R8: line_start=1 with fine_x=s moves the held row into the shift registers and discards its first s pixels. The next 8-s enabled pixels are the rest of that row, and the next row follows them.
- R9: pix_pal and pix_prio carry the attributes that were loaded with the row the output pixel belongs to.
- R10: pix_transp is 1 exactly when the output pixel's colour index is 0.
- R11: In a cycle with both line_start=1 and pix_en=1, line_start wins. No pixel is output for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Write a tile row into the holding register |
| ld_planes | input | PLANES*8 | Plane bytes of the row; plane p is in bits [p*8+7:p*8] |
| ld_pal | input | PAL_W | Palette attribute of the row |
| ld_prio | input | 1 | Priority attribute of the row |
| ld_hflip | input | 1 | Mirror the row horizontally at load time |
| line_start | input | 1 | Start a line: transfer the held row and apply fine_x |
| fine_x | input | 3 | Number of leading pixels to drop at line start (0 to 7) |
| pix_en | input | 1 | Pixel-clock enable: output one pixel |
| pix_valid | output | 1 | A new pixel is on the outputs |
| pix_index | output | PLANES | Colour index |
| pix_pal | output | PAL_W | Palette of the pixel's row |
| pix_prio | output | 1 | Priority of the pixel's row |
| pix_transp | output | 1 | Colour index is zero |

## Verification
The bench builds the block with four planes and a three-bit palette. With four planes the index can take all sixteen values, so a wrong plane order or a swapped bit shows up as a wrong index rather than cancelling out, and index 0 occurs both from all-zero rows and from chance patterns in random rows. Every fine scroll value from 0 to 7 is reachable through random line starts. Loads that coincide with a transfer edge, which is the tightest timing for holding-register reuse, also occur in the random part of the run.

// File: rtl/tps_pkg.sv
package tps_pkg;
    localparam int TILE_W = 8;
    localparam int POS_W  = $clog2(TILE_W);

    function automatic logic [TILE_W-1:0] mirror_row(input logic [TILE_W-1:0] r);
        logic [TILE_W-1:0] m;
        for (int i = 0; i < TILE_W; i++) begin
            m[i] = r[TILE_W-1-i];
        end
        return m;
    endfunction
endpackage

// File: rtl/tps_hold_reg.sv
module tps_hold_reg
    import tps_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int PAL_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_valid,
    input  logic [PLANES*TILE_W-1:0]   ld_planes,
    input  logic [PAL_W-1:0]           ld_pal,
    input  logic                       ld_prio,
    input  logic                       ld_hflip,
    output logic [PLANES*TILE_W-1:0]   hold_planes,
    output logic [PAL_W-1:0]           hold_pal,
    output logic                       hold_prio
);
    typedef struct packed {
        logic [PLANES*TILE_W-1:0] planes;
        logic [PAL_W-1:0]         pal;
        logic                     prio;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (ld_valid) begin
            for (int p = 0; p < PLANES; p++) begin
                hold_d.planes[p*TILE_W +: TILE_W] = ld_hflip
                    ? mirror_row(ld_planes[p*TILE_W +: TILE_W])
                    : ld_planes[p*TILE_W +: TILE_W];
            end
            hold_d.pal  = ld_pal;
            hold_d.prio = ld_prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold_planes = hold_q.planes;
    assign hold_pal    = hold_q.pal;
    assign hold_prio   = hold_q.prio;
endmodule

// File: rtl/tps_plane_lane.sv
module tps_plane_lane
    import tps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic              shift,
    input  logic [POS_W-1:0]  skip,
    input  logic [TILE_W-1:0] hold_row,
    output logic              head
);
    logic [TILE_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (xfer) begin
            row_d = hold_row << skip;
        end else if (shift) begin
            row_d = row_q << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign head = row_q[TILE_W-1];
endmodule

// File: rtl/tile_pixel_shifter.sv
module tile_pixel_shifter
    import tps_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int PAL_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_valid,
    input  logic [PLANES*TILE_W-1:0]    ld_planes,
    input  logic [PAL_W-1:0]            ld_pal,
    input  logic                        ld_prio,
    input  logic                        ld_hflip,
    input  logic                        line_start,
    input  logic [POS_W-1:0]            fine_x,
    input  logic                        pix_en,
    output logic                        pix_valid,
    output logic [PLANES-1:0]           pix_index,
    output logic [PAL_W-1:0]            pix_pal,
    output logic                        pix_prio,
    output logic                        pix_transp
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(TILE_W - 1);

    typedef struct packed {
        logic [POS_W-1:0]  cnt;
        logic [PAL_W-1:0]  pal;
        logic              prio;
        logic              vld;
        logic [PLANES-1:0] idx;
        logic [PAL_W-1:0]  opal;
        logic              oprio;
        logic              transp;
    } st_t;

    st_t st_d, st_q;

    logic [PLANES*TILE_W-1:0] hold_planes;
    logic [PAL_W-1:0]         hold_pal;
    logic                     hold_prio;
    logic [PLANES-1:0]        head;
    logic                     adv, wrap, xfer, shift;
    logic [POS_W-1:0]         skip;

    tps_hold_reg #(.PLANES(PLANES), .PAL_W(PAL_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .ld_planes   (ld_planes),
        .ld_pal      (ld_pal),
        .ld_prio     (ld_prio),
        .ld_hflip    (ld_hflip),
        .hold_planes (hold_planes),
        .hold_pal    (hold_pal),
        .hold_prio   (hold_prio)
    );

    // Pixel advance and row transfer decisions; line start outranks the pixel enable.
    always_comb begin
        adv   = pix_en && !line_start;
        wrap  = adv && (st_q.cnt == LAST_POS);
        xfer  = line_start || wrap;
        shift = adv && !wrap;
        skip  = line_start ? fine_x : '0;
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        tps_plane_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .xfer     (xfer),
            .shift    (shift),
            .skip     (skip),
            .hold_row (hold_planes[p*TILE_W +: TILE_W]),
            .head     (head[p])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = adv;
        if (adv) begin
            st_d.idx    = head;
            st_d.opal   = st_q.pal;
            st_d.oprio  = st_q.prio;
            st_d.transp = (head == '0);
        end
        if (line_start) begin
            st_d.cnt  = fine_x;
            st_d.pal  = hold_pal;
            st_d.prio = hold_prio;
        end else if (wrap) begin
            st_d.cnt  = '0;
            st_d.pal  = hold_pal;
            st_d.prio = hold_prio;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.transp <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_valid  = st_q.vld;
    assign pix_index  = st_q.idx;
    assign pix_pal    = st_q.opal;
    assign pix_prio   = st_q.oprio;
    assign pix_transp = st_q.transp;
endmodule

// File: rtl/tps_checker.sv
module tps_checker
    import tps_pkg::*;
#(
    parameter int PLANES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_en,
    input logic              line_start,
    input logic [POS_W-1:0]  fine_x,
    input logic              pix_valid,
    input logic [PLANES-1:0] pix_index,
    input logic              pix_transp,
    input logic [POS_W-1:0]  cnt
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(TILE_W - 1);

    a_r5_valid_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !line_start) |=> pix_valid);

    a_r5_no_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> !pix_valid);

    a_r5_output_held: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> $stable(pix_index));

    a_r11_line_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !pix_valid);

    a_r10_transparent_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_transp == (pix_index == '0)));

    a_r6_row_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !line_start && cnt == LAST_POS) |=> (cnt == '0));

    a_r6_row_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !line_start && cnt != LAST_POS) |=> (cnt == $past(cnt) + 1'b1));

    a_r8_scroll_start: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (cnt == $past(fine_x)));
endmodule

bind tile_pixel_shifter tps_checker #(.PLANES(PLANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_en     (pix_en),
    .line_start (line_start),
    .fine_x     (fine_x),
    .pix_valid  (pix_valid),
    .pix_index  (pix_index),
    .pix_transp (pix_transp),
    .cnt        (st_q.cnt)
);

// File: tb/sim_tile_pixel_shifter.sv
`timescale 1ns/1ps
module sim_tile_pixel_shifter;
    localparam int NP = 4;
    localparam int PW = 3;

    typedef struct packed {
        logic [NP*8-1:0] planes;
        logic            flip;
        logic [PW-1:0]   pal;
        logic            prio;
    } tile_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_valid = 1'b0;
    logic [NP*8-1:0] ld_planes = '0;
    logic [PW-1:0]   ld_pal = '0;
    logic            ld_prio = 1'b0;
    logic            ld_hflip = 1'b0;
    logic            line_start = 1'b0;
    logic [2:0]      fine_x = '0;
    logic            pix_en = 1'b0;
    logic            pix_valid;
    logic [NP-1:0]   pix_index;
    logic [PW-1:0]   pix_pal;
    logic            pix_prio;
    logic            pix_transp;

    int compared = 0;
    int mismatched = 0;

    // Reference state built from the requirements
    tile_t         m_hold = '0;
    tile_t         m_cur  = '0;
    int            m_pos  = 0;
    logic          e_vld  = 1'b0;
    logic [NP-1:0] e_idx  = '0;
    logic [PW-1:0] e_pal  = '0;
    logic          e_prio = 1'b0;

    always #2 clk = ~clk;

    tile_pixel_shifter #(.PLANES(NP), .PAL_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_planes(ld_planes),
        .ld_pal(ld_pal), .ld_prio(ld_prio), .ld_hflip(ld_hflip),
        .line_start(line_start), .fine_x(fine_x), .pix_en(pix_en),
        .pix_valid(pix_valid), .pix_index(pix_index), .pix_pal(pix_pal),
        .pix_prio(pix_prio), .pix_transp(pix_transp)
    );

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Pixel at display position pos of a row (R2, R3, R4)
    function automatic logic [NP-1:0] px(input tile_t t, input int pos);
        logic [NP-1:0] v;
        for (int p = 0; p < NP; p++) begin
            v[p] = t.flip ? t.planes[p*8 + pos] : t.planes[p*8 + 7 - pos];
        end
        return v;
    endfunction

    task automatic tick(input bit ls, input int fx, input bit en, input bit ld,
                        input tile_t t, input string tag);
        line_start = ls;
        fine_x     = 3'(fx);
        pix_en     = en;
        ld_valid   = ld;
        ld_planes  = t.planes;
        ld_hflip   = t.flip;
        ld_pal     = t.pal;
        ld_prio    = t.prio;
        @(posedge clk);
        e_vld = en && !ls;
        if (ls) begin
            m_cur = m_hold;
            m_pos = fx;
        end else if (en) begin
            e_idx  = px(m_cur, m_pos);
            e_pal  = m_cur.pal;
            e_prio = m_cur.prio;
            if (m_pos == 7) begin
                m_cur = m_hold;
                m_pos = 0;
            end else begin
                m_pos++;
            end
        end
        if (ld) m_hold = t;
        @(negedge clk);
        chk(ls ? "R11" : "R5", pix_valid, e_vld);
        chk(e_vld ? tag : "R5", pix_index, e_idx);
        chk("R9", pix_pal, e_pal);
        chk("R9", pix_prio, e_prio);
        chk("R10", pix_transp, (e_idx == '0));
    endtask

    function automatic tile_t mk(input logic [31:0] pl, input bit f, input int pal, input bit pr);
        tile_t t;
        t.planes = pl;
        t.flip   = f;
        t.pal    = PW'(pal);
        t.prio   = pr;
        return t;
    endfunction

    function automatic tile_t rnd_tile();
        return mk($urandom, 1'($urandom), int'($urandom % 8), 1'($urandom));
    endfunction

    initial begin
        tile_t z = '0;
        int unsigned seed_sink;
        seed_sink = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", pix_valid, 0);
        chk("R1", pix_index, 0);
        chk("R1", pix_pal, 0);
        chk("R1", pix_prio, 0);
        chk("R1", pix_transp, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: held and displayed rows start at zero
        for (int i = 0; i < 3; i++) tick(0, 0, 1, 0, z, "R1");

        // R3 and R2: plain row, then R4 and R6: mirrored row follows seamlessly
        tick(0, 0, 0, 1, mk(32'h0FF03CA5, 0, 5, 1), "R3");
        tick(1, 0, 0, 1, mk(32'h81C3E718, 1, 2, 0), "R3");
        for (int i = 0; i < 8; i++) tick(0, 0, 1, 0, z, "R3");
        for (int i = 0; i < 8; i++) tick(0, 0, 1, 0, z, "R4");

        // R7: two loads during a row, the later one is shown next
        tick(1, 0, 0, 1, mk(32'h12345678, 0, 1, 1), "R7");
        tick(0, 0, 1, 1, mk(32'hDEADBEEF, 0, 3, 0), "R7");
        tick(0, 0, 1, 0, z, "R7");
        tick(0, 0, 1, 1, mk(32'hCAFEF00D, 0, 6, 1), "R7");
        for (int i = 0; i < 13; i++) tick(0, 0, 1, 0, z, "R7");

        // R8: fine scroll of 5, then R6 next row
        tick(0, 0, 0, 1, mk(32'hA0B1C2D3, 0, 4, 1), "R8");
        tick(1, 5, 0, 1, mk(32'h55AA33CC, 1, 7, 0), "R8");
        for (int i = 0; i < 11; i++) tick(0, 0, 1, 0, z, "R8");

        // R11: line start and pixel enable together
        tick(1, 7, 1, 0, z, "R11");
        tick(0, 0, 1, 0, z, "R11");

        // R5: idle cycles hold outputs
        for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, z, "R5");

        // R10: all-zero row is transparent
        tick(0, 0, 0, 1, mk(32'h0, 0, 3, 1), "R10");
        tick(1, 0, 0, 0, z, "R10");
        for (int i = 0; i < 8; i++) tick(0, 0, 1, 0, z, "R10");

        // R2: random mix of loads, line starts, enables and scrolls
        for (int i = 0; i < 4000; i++) begin
            bit ls = ($urandom % 100) < 3;
            bit en = ($urandom % 100) < 70;
            bit ld = ($urandom % 100) < 25;
            tick(ls, int'($urandom % 8), en, ld, rnd_tile(), "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule